// File: doc/BRIEF.md
# External Interrupt Priority Arbiter

This block gathers every pending external interrupt source of a processor core and offers at most one of them at a time. There are three kinds of source: a last-in first-out stack of posted events, each carrying an interruption code and two parameters, a clock-comparator event and a CPU-timer event. The two timer events each set their own pending bit when they fire.

The core takes an offer only while it is enabled for external interrupts and no other exception is being delivered. The arbiter then picks the best source, latches its code and parameters into an offer register, and holds them there until the core accepts. A stacked event leaves the stack when it is offered and is retired on accept. A timer event keeps its pending bit until the accept. A hard-interrupt request stays high while anything is pending or on offer.

Two kinds of misuse are reported on one-cycle flags and change no state: an accept given when no offer is valid or the enable mask is clear, and a push into a full stack.

Top module: `ext_irq_arbiter`

## Requirements
- R1: After reset, irq_valid, irq_src, hard_req, queue_pend, push_overflow and deliver_fault are all 0.
- R2: A new offer is latched only on an edge where ext_mask is 1 and exc_active is 0 and some source is pending, and irq_valid is high from the cycle that follows that edge.
- R3: When an offer is latched, a non-empty event stack wins over a pending clock-comparator event, which wins over a pending CPU-timer event.
- R4: irq_src reads 0 when there is no offer, 1 for a stacked event, 2 for the clock comparator and 3 for the CPU timer. The clock-comparator offer carries code 16'h1004 and the CPU-timer offer carries code 16'h1005. Both timer offers carry zero in both parameters.
- R5: Stacked events are offered most recent first, each with exactly the 16-bit code, 32-bit parameter and 64-bit parameter that were pushed with it.
- R6: While irq_valid is high, irq_src, irq_code, irq_parm and irq_parm_wide hold steady until irq_accept is high on an edge with ext_mask at 1. irq_valid is low in the cycle after that accept.
- R7: queue_pend is high while the stack holds an event or a stacked event is on offer. It falls in the cycle after the accept of the last stacked event.
- R8: A firing timer event sets its pending bit, and hard_req is high in the next cycle. The bit is cleared by the accept of that source's offer.
- R9: hard_req is low once no event is stacked, no timer bit is pending and no offer is valid.
- R10: A push while DEPTH events (default 16) are stored is discarded, and push_overflow is high for exactly the next cycle.
- R11: An irq_accept given with irq_valid low or ext_mask low raises deliver_fault for exactly the next cycle, and it neither retires the offer nor changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_push | input | 1 | Post one event onto the stack |
| ev_code | input | 16 | Interruption code of the posted event |
| ev_parm | input | 32 | 32-bit parameter of the posted event |
| ev_parm_wide | input | 64 | 64-bit parameter of the posted event |
| clkcmp_fire | input | 1 | Clock-comparator event pulse |
| cputmr_fire | input | 1 | CPU-timer event pulse |
| ext_mask | input | 1 | Core is enabled for external interrupts |
| exc_active | input | 1 | Another exception is being delivered |
| irq_accept | input | 1 | Core accepts the current offer |
| irq_valid | output | 1 | An offer is presented |
| irq_src | output | 2 | Source of the offer (0 none, 1 stack, 2 clock comparator, 3 CPU timer) |
| irq_code | output | 16 | Interruption code of the offer |
| irq_parm | output | 32 | 32-bit parameter of the offer |
| irq_parm_wide | output | 64 | 64-bit parameter of the offer |
| queue_pend | output | 1 | Stacked events remain, including one on offer |
| hard_req | output | 1 | Hard-interrupt request to the core |
| push_overflow | output | 1 | A push was dropped because the stack was full |
| deliver_fault | output | 1 | An accept was given outside a valid, enabled offer |

## Verification
The assertions assume that the two misuse flags use the registered variant, so each flag lags its cause by one edge. They also assume that the core gives an accept only during an offer and with the mask set, except in the deliberate fault cases, which the properties tie to the flag itself. The stimulus posts events and fires timers only while ext_mask is low, and drains with the mask high, so every offer can be predicted from a simple stack and two pending bits. The directed steps cover the misuse cases separately: a gated accept during a held offer, an accept with no offer, and a push onto a full stack.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;

   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_QUEUE  = 2'd1,
      SRC_CLKCMP = 2'd2,
      SRC_CPUTMR = 2'd3
   } irq_src_e;

   localparam int          NUM_TMR      = 2;
   localparam int          TMR_CLKCMP   = 0;
   localparam int          TMR_CPUTMR   = 1;
   localparam logic [15:0] CODE_CLKCMP  = 16'h1004;
   localparam logic [15:0] CODE_CPUTMR  = 16'h1005;

endpackage

// File: rtl/ext_irq_lifo.sv
`timescale 1ns/1ps
module ext_irq_lifo #(
   parameter int DEPTH = 16,
   parameter int ENT_W = 112,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [ENT_W-1:0] push_data,
   input  logic             pop,
   output logic [ENT_W-1:0] top_data,
   output logic             empty,
   output logic             push_drop
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] rd_pos;
   logic [CNT_W-1:0] wr_pos;
   logic             full;
   logic             pop_ok;
   logic             push_ok;
   logic [ENT_W-1:0] slot [DEPTH];

   always_comb begin
      full      = (cnt == CNT_W'(DEPTH));
      empty     = (cnt == '0);
      pop_ok    = pop && !empty;
      push_ok   = push && (!full || pop_ok);
      push_drop = push && !push_ok;
      rd_pos    = cnt - CNT_W'(1);
      // a pop and a push on one edge reuse the slot being vacated
      wr_pos    = pop_ok ? rd_pos : cnt;
      top_data  = empty ? '0 : slot[rd_pos[IDX_W-1:0]];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + CNT_W'(1);
            2'b01:   cnt <= cnt - CNT_W'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) begin
         slot[wr_pos[IDX_W-1:0]] <= push_data;
      end
   end

endmodule

// File: rtl/ext_irq_pend.sv
`timescale 1ns/1ps
module ext_irq_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic retire,
   output logic pend
);

   // a fire on the retiring edge wins, so no event is lost
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else begin
         pend <= fire | (pend & ~retire);
      end
   end

endmodule

// File: rtl/ext_irq_select.sv
`timescale 1ns/1ps
module ext_irq_select
   import ext_irq_pkg::*;
#(
   parameter int          CODE_W  = 16,
   parameter int          PARM_W  = 32,
   parameter int          WIDE_W  = 64,
   parameter logic [15:0] CC_CODE = CODE_CLKCMP,
   parameter logic [15:0] CT_CODE = CODE_CPUTMR,
   localparam int         ENT_W   = CODE_W + PARM_W + WIDE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               q_avail,
   input  logic [ENT_W-1:0]   q_entry,
   input  logic [NUM_TMR-1:0] tmr_pend,
   input  logic               ext_mask,
   input  logic               exc_active,
   input  logic               accept,
   output logic               offer_valid,
   output irq_src_e           offer_src,
   output logic [ENT_W-1:0]   offer_entry,
   output logic               take_q,
   output logic [NUM_TMR-1:0] tmr_retire,
   output logic               bad_accept
);

   localparam int TAIL_W = ENT_W - CODE_W;

   logic             eligible;
   logic             capture;
   logic             acc_ok;
   irq_src_e         pick_src;
   logic [ENT_W-1:0] pick_entry;

   always_comb begin
      eligible = ext_mask && !exc_active;
      if (q_avail) begin
         pick_src   = SRC_QUEUE;
         pick_entry = q_entry;
      end else if (tmr_pend[TMR_CLKCMP]) begin
         pick_src   = SRC_CLKCMP;
         pick_entry = {CC_CODE[CODE_W-1:0], {TAIL_W{1'b0}}};
      end else if (tmr_pend[TMR_CPUTMR]) begin
         pick_src   = SRC_CPUTMR;
         pick_entry = {CT_CODE[CODE_W-1:0], {TAIL_W{1'b0}}};
      end else begin
         pick_src   = SRC_NONE;
         pick_entry = '0;
      end
      capture    = !offer_valid && eligible && (pick_src != SRC_NONE);
      take_q     = capture && (pick_src == SRC_QUEUE);
      acc_ok     = accept && offer_valid && ext_mask;
      bad_accept = accept && !acc_ok;
      tmr_retire = '0;
      tmr_retire[TMR_CLKCMP] = acc_ok && (offer_src == SRC_CLKCMP);
      tmr_retire[TMR_CPUTMR] = acc_ok && (offer_src == SRC_CPUTMR);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         offer_valid <= 1'b0;
         offer_src   <= SRC_NONE;
         offer_entry <= '0;
      end else if (acc_ok) begin
         offer_valid <= 1'b0;
         offer_src   <= SRC_NONE;
         offer_entry <= '0;
      end else if (capture) begin
         offer_valid <= 1'b1;
         offer_src   <= pick_src;
         offer_entry <= pick_entry;
      end
   end

endmodule

// File: rtl/ext_irq_arbiter.sv
`timescale 1ns/1ps
module ext_irq_arbiter
   import ext_irq_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int CODE_W    = 16,
   parameter int PARM_W    = 32,
   parameter int WIDE_W    = 64,
   parameter bit REG_FLAGS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_push,
   input  logic [CODE_W-1:0] ev_code,
   input  logic [PARM_W-1:0] ev_parm,
   input  logic [WIDE_W-1:0] ev_parm_wide,
   input  logic              clkcmp_fire,
   input  logic              cputmr_fire,
   input  logic              ext_mask,
   input  logic              exc_active,
   input  logic              irq_accept,
   output logic              irq_valid,
   output logic [1:0]        irq_src,
   output logic [CODE_W-1:0] irq_code,
   output logic [PARM_W-1:0] irq_parm,
   output logic [WIDE_W-1:0] irq_parm_wide,
   output logic              queue_pend,
   output logic              hard_req,
   output logic              push_overflow,
   output logic              deliver_fault
);

   localparam int ENT_W = CODE_W + PARM_W + WIDE_W;

   if (DEPTH < 1) begin : g_bad_depth
      $error("ext_irq_arbiter: DEPTH must be at least 1");
   end
   if (CODE_W != 16) begin : g_bad_code
      $error("ext_irq_arbiter: CODE_W must be 16 to hold the timer codes");
   end
   if (PARM_W < 1 || WIDE_W < 1) begin : g_bad_parm
      $error("ext_irq_arbiter: parameter widths must be positive");
   end

   logic [ENT_W-1:0]   top_entry;
   logic               q_empty;
   logic               push_drop;
   logic               take_q;
   logic               bad_accept;
   logic [NUM_TMR-1:0] tmr_fire;
   logic [NUM_TMR-1:0] tmr_retire;
   logic [NUM_TMR-1:0] tmr_pend;
   irq_src_e           offer_src;
   logic [ENT_W-1:0]   offer_entry;
   logic               offer_valid;

   ext_irq_lifo #(
      .DEPTH (DEPTH),
      .ENT_W (ENT_W)
   ) i_lifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ev_push),
      .push_data ({ev_code, ev_parm, ev_parm_wide}),
      .pop       (take_q),
      .top_data  (top_entry),
      .empty     (q_empty),
      .push_drop (push_drop)
   );

   always_comb begin
      tmr_fire             = '0;
      tmr_fire[TMR_CLKCMP] = clkcmp_fire;
      tmr_fire[TMR_CPUTMR] = cputmr_fire;
   end

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      ext_irq_pend i_pend (
         .clk    (clk),
         .rst_n  (rst_n),
         .fire   (tmr_fire[t]),
         .retire (tmr_retire[t]),
         .pend   (tmr_pend[t])
      );
   end

   ext_irq_select #(
      .CODE_W (CODE_W),
      .PARM_W (PARM_W),
      .WIDE_W (WIDE_W)
   ) i_select (
      .clk         (clk),
      .rst_n       (rst_n),
      .q_avail     (!q_empty),
      .q_entry     (top_entry),
      .tmr_pend    (tmr_pend),
      .ext_mask    (ext_mask),
      .exc_active  (exc_active),
      .accept      (irq_accept),
      .offer_valid (offer_valid),
      .offer_src   (offer_src),
      .offer_entry (offer_entry),
      .take_q      (take_q),
      .tmr_retire  (tmr_retire),
      .bad_accept  (bad_accept)
   );

   if (REG_FLAGS) begin : g_flag_reg
      logic ovf_q;
      logic flt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ovf_q <= 1'b0;
            flt_q <= 1'b0;
         end else begin
            ovf_q <= push_drop;
            flt_q <= bad_accept;
         end
      end
      assign push_overflow = ovf_q;
      assign deliver_fault = flt_q;
   end else begin : g_flag_comb
      assign push_overflow = push_drop;
      assign deliver_fault = bad_accept;
   end

   always_comb begin
      irq_valid     = offer_valid;
      irq_src       = offer_src;
      irq_code      = offer_entry[ENT_W-1 -: CODE_W];
      irq_parm      = offer_entry[WIDE_W +: PARM_W];
      irq_parm_wide = offer_entry[WIDE_W-1:0];
      queue_pend    = !q_empty || (offer_valid && offer_src == SRC_QUEUE);
      hard_req      = !q_empty || (|tmr_pend) || offer_valid;
   end

endmodule

// File: rtl/ext_irq_arbiter_chk.sv
`timescale 1ns/1ps
module ext_irq_arbiter_chk #(
   parameter int CODE_W = 16,
   parameter int PARM_W = 32,
   parameter int WIDE_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_push,
   input logic              clkcmp_fire,
   input logic              cputmr_fire,
   input logic              ext_mask,
   input logic              exc_active,
   input logic              irq_accept,
   input logic              irq_valid,
   input logic [1:0]        irq_src,
   input logic [CODE_W-1:0] irq_code,
   input logic [PARM_W-1:0] irq_parm,
   input logic [WIDE_W-1:0] irq_parm_wide,
   input logic              queue_pend,
   input logic              hard_req,
   input logic              push_overflow,
   input logic              deliver_fault
);

   // R6
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && !(irq_accept && ext_mask)) |=>
      (irq_valid && $stable(irq_src) && $stable(irq_code)
       && $stable(irq_parm) && $stable(irq_parm_wide)));

   // R6
   offer_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_accept && ext_mask) |=> !irq_valid);

   // R2
   capture_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_valid) |-> ($past(ext_mask) && !$past(exc_active)));

   // R4
   clkcmp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_src == 2'd2) |->
      (irq_code == 16'h1004 && irq_parm == '0 && irq_parm_wide == '0));

   // R4
   cputmr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_src == 2'd3) |->
      (irq_code == 16'h1005 && irq_parm == '0 && irq_parm_wide == '0));

   // R4
   src_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid == (irq_src != 2'd0));

   // R7
   queue_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_src == 2'd1) |-> queue_pend);

   // R8
   timer_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clkcmp_fire || cputmr_fire) |=> hard_req);

   // R9
   idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hard_req |-> (!irq_valid && !queue_pend));

   // R10
   overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_overflow |-> $past(ev_push));

   // R11
   fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_accept && !(irq_valid && ext_mask)) |=> deliver_fault);

   // R11
   fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deliver_fault |-> $past(irq_accept));

endmodule

bind ext_irq_arbiter ext_irq_arbiter_chk i_chk (.*);

// File: tb/test_ext_irq_arbiter.sv
`timescale 1ns/1ps
module test_ext_irq_arbiter;

   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ev_push;
   logic [15:0] ev_code;
   logic [31:0] ev_parm;
   logic [63:0] ev_parm_wide;
   logic        clkcmp_fire;
   logic        cputmr_fire;
   logic        ext_mask;
   logic        exc_active;
   logic        irq_accept;
   logic        irq_valid;
   logic [1:0]  irq_src;
   logic [15:0] irq_code;
   logic [31:0] irq_parm;
   logic [63:0] irq_parm_wide;
   logic        queue_pend;
   logic        hard_req;
   logic        push_overflow;
   logic        deliver_fault;

   always #2.5 clk = ~clk;

   ext_irq_arbiter #(.DEPTH(DEPTH)) i_ext_irq_arbiter (.*);

   int total = 0;
   int bad   = 0;

   logic [15:0] m_code [DEPTH];
   logic [31:0] m_parm [DEPTH];
   logic [63:0] m_wide [DEPTH];
   int          m_cnt = 0;
   bit          m_cc  = 0;
   bit          m_ct  = 0;

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push_ev(logic [15:0] c, logic [31:0] p, logic [63:0] w);
      ev_push = 1'b1; ev_code = c; ev_parm = p; ev_parm_wide = w;
      tick();
      ev_push = 1'b0;
      if (m_cnt < DEPTH) begin
         m_code[m_cnt] = c; m_parm[m_cnt] = p; m_wide[m_cnt] = w;
         m_cnt++;
      end
   endtask

   task automatic fire(bit cc, bit ct);
      clkcmp_fire = cc; cputmr_fire = ct;
      tick();
      clkcmp_fire = 1'b0; cputmr_fire = 1'b0;
      if (cc) m_cc = 1;
      if (ct) m_ct = 1;
   endtask

   function automatic logic [1:0] exp_src();
      if (m_cnt > 0) return 2'd1;
      if (m_cc)      return 2'd2;
      if (m_ct)      return 2'd3;
      return 2'd0;
   endfunction

   // checks the offer against the model, accepts it and updates the model
   task automatic take_one(string tag);
      logic [1:0] s;
      for (int w = 0; w < 4 && !irq_valid; w++) tick();
      s = exp_src();
      chk("R3", {tag, " source"}, 64'(irq_src), 64'(s));
      if (s == 2'd1) begin
         chk("R5", {tag, " code"}, 64'(irq_code), 64'(m_code[m_cnt-1]));
         chk("R5", {tag, " parm"}, 64'(irq_parm), 64'(m_parm[m_cnt-1]));
         chk("R5", {tag, " wide"}, irq_parm_wide, m_wide[m_cnt-1]);
         m_cnt--;
      end else begin
         chk("R4", {tag, " timer code"}, 64'(irq_code),
             (s == 2'd2) ? 64'h1004 : 64'h1005);
         chk("R4", {tag, " timer parms"}, 64'(irq_parm) | irq_parm_wide, 64'd0);
         if (s == 2'd2) m_cc = 0; else m_ct = 0;
      end
      irq_accept = 1'b1;
      tick();
      irq_accept = 1'b0;
      chk("R6", {tag, " valid after accept"}, 64'(irq_valid), 64'd0);
   endtask

   task automatic drain(string tag);
      while (m_cnt > 0 || m_cc || m_ct) take_one(tag);
      tick(); tick();
      chk("R9", {tag, " idle valid"}, 64'(irq_valid), 64'd0);
      chk("R9", {tag, " idle hard_req"}, 64'(hard_req), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] held;
      void'($urandom(32'd2718));
      rst_n = 1'b0; ev_push = 1'b0; ev_code = '0; ev_parm = '0; ev_parm_wide = '0;
      clkcmp_fire = 1'b0; cputmr_fire = 1'b0; ext_mask = 1'b0; exc_active = 1'b0;
      irq_accept = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1", "irq_valid", 64'(irq_valid), 64'd0);
      chk("R1", "irq_src", 64'(irq_src), 64'd0);
      chk("R1", "hard_req", 64'(hard_req), 64'd0);
      chk("R1", "queue_pend", 64'(queue_pend), 64'd0);
      chk("R1", "flags", 64'({push_overflow, deliver_fault}), 64'd0);

      // R8 timer raises the request, masked so no offer (R2)
      fire(0, 1);
      chk("R8", "hard_req after cpu timer", 64'(hard_req), 64'd1);
      chk("R2", "masked no offer", 64'(irq_valid), 64'd0);
      chk("R7", "queue_pend timer only", 64'(queue_pend), 64'd0);

      push_ev(16'h0A01, 32'h1111_0001, 64'hA5A5_0000_0000_0001);
      push_ev(16'h0A02, 32'h2222_0002, 64'h5A5A_FFFF_0000_0002);
      chk("R7", "queue_pend with entries", 64'(queue_pend), 64'd1);
      fire(1, 0);

      // R2 blocked while another exception is in progress
      exc_active = 1'b1; ext_mask = 1'b1;
      repeat (3) tick();
      chk("R2", "busy no offer", 64'(irq_valid), 64'd0);
      exc_active = 1'b0;
      tick();
      chk("R2", "offer one cycle after eligible", 64'(irq_valid), 64'd1);
      chk("R3", "stack before timers", 64'(irq_src), 64'd1);
      chk("R5", "most recent first", 64'(irq_code), 64'h0A02);
      held = irq_code;
      repeat (3) tick();
      chk("R6", "offer held", 64'(irq_code), 64'(held));

      // R11 accept with mask clear: flagged, offer kept
      ext_mask = 1'b0; irq_accept = 1'b1;
      tick();
      irq_accept = 1'b0; ext_mask = 1'b1;
      chk("R11", "fault on masked accept", 64'(deliver_fault), 64'd1);
      chk("R11", "offer kept", 64'(irq_valid), 64'd1);
      chk("R11", "offer unchanged", 64'(irq_code), 64'(held));
      tick();
      chk("R11", "fault one cycle", 64'(deliver_fault), 64'd0);

      take_one("first");
      take_one("second");
      chk("R7", "queue_pend clears after last", 64'(queue_pend), 64'd0);
      chk("R9", "hard_req with timers", 64'(hard_req), 64'd1);
      drain("timers");

      // R11 accept with no offer
      irq_accept = 1'b1;
      tick();
      irq_accept = 1'b0;
      chk("R11", "fault with no offer", 64'(deliver_fault), 64'd1);
      chk("R11", "still no offer", 64'(irq_valid), 64'd0);

      // R10 overflow
      ext_mask = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         push_ev(16'h0B00 + 16'(i), 32'(i * 7), {32'hC0DE_0000, 32'(i)});
      chk("R10", "no overflow at depth", 64'(push_overflow), 64'd0);
      push_ev(16'hDEAD, 32'hDEAD, 64'hDEAD);
      chk("R10", "overflow on full push", 64'(push_overflow), 64'd1);
      tick();
      chk("R10", "overflow one cycle", 64'(push_overflow), 64'd0);
      ext_mask = 1'b1;
      drain("overflow");

      // random rounds
      for (int r = 0; r < 40; r++) begin
         ext_mask = 1'b0;
         for (int k = 0; k < int'($urandom_range(0, 7)); k++) begin
            if ($urandom_range(0, 3) == 0)
               fire($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
            else
               push_ev(16'($urandom), $urandom, {$urandom, $urandom});
         end
         ext_mask = 1'b1;
         drain("random");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule